// File: doc/BRIEF.md
# USB Charger Detection Controller

This block decides what kind of power source has been plugged into a USB receptacle and reports the result to the rest of the system. It watches a supply-valid flag, a data-contact flag, the results of two analog detection comparators, level-window and pull-up flags for each data line, a battery-good input from the system, and a slow timebase tick. Once the supply is valid it tries data contact detection. If contact is seen, it settles, then runs the primary and secondary stages. If contact never arrives before the timeout, it falls back to a classification based on the data-line voltage windows.

When classification finishes, the block drives three status signals: a charge-permit indication (an open-drain low-drive enable), a high-current flag (push-pull), and a switch-closed indication (an open-drain low-drive enable). It also drives the enable of the data-path switch. The switch closes only for host-type ports, and only while the battery is good.

If the battery stays bad for too long after a charger has been identified, a dead-battery timer withdraws the charge permit. A later rising edge on battery-good starts detection again. Every duration is a parameter counted in timebase ticks, and all asynchronous inputs pass through two-flop synchronizers.

Top module: `usb_chg_detect`

## Requirements
- R1: While `vbus_valid` is low the outputs are released: `chg_allow_pull`=0, `chg_hi_current`=0, `sw_open_pull`=0, `data_sw_en`=0. Losing `vbus_valid` in any state returns the block to this condition within four clocks.
- R2: If contact is seen and `prim_is_charger`=0 (a host port with no charging capability), the result is `chg_allow_pull`=1 and `chg_hi_current`=0.
- R3: If contact is seen with `prim_is_charger`=1 and `sec_is_dedicated`=0 (a charging host port), the result is `chg_allow_pull`=1 and `chg_hi_current`=1.
- R4: If contact is seen with `prim_is_charger`=1 and `sec_is_dedicated`=1 (a dedicated charger), the result is `chg_allow_pull`=1 and `chg_hi_current`=1, and the switch stays open whatever the state of `batt_good`.
- R5: `data_sw_en` and `sw_open_pull` are 1 only for the two host-port results, and only while `batt_good` is 1. In every other case both are 0.
- R6: If contact detection times out and both lines flag window A, or both lines flag window B (`dp_in_win_a`&`dm_in_win_a`, or `dp_in_win_b`&`dm_in_win_b`), the result is `chg_allow_pull`=1, `chg_hi_current`=1, and the switch is open. Window A is tested first.
- R7: If contact detection times out and neither window matches on both lines, the result is `chg_allow_pull`=1, `chg_hi_current`=0, and the switch is open. This covers both lines pulled up, both lines open, and mixed flags.
- R8: A contact flag that rises only after the detection timeout has expired does not change the result. A slow insertion of a dedicated charger therefore reads as a low-current charger.
- R9: While detection is in progress, the outputs keep the values they held before detection started.
- R10: After a result, if `batt_good` stays low for `DBP_TICKS` consecutive ticks, all outputs are released as in R1. A high pulse on `batt_good` before that point restarts the count.
- R11: After the dead-battery expiry, a rising edge on `batt_good` reruns detection. The outputs stay released until the new result appears.
- R12: Every phase advances only on `tick`. With `tick` held low, no detection result ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vbus_valid | input | 1 | Supply above valid threshold (asynchronous) |
| dcd_contact | input | 1 | Data contact detected (asynchronous) |
| prim_is_charger | input | 1 | Primary stage: 1 when the port is not a plain host port |
| sec_is_dedicated | input | 1 | Secondary stage: 1 for a dedicated charger, 0 for a charging host |
| dp_in_win_a | input | 1 | D+ inside voltage window A |
| dm_in_win_a | input | 1 | D- inside voltage window A |
| dp_in_win_b | input | 1 | D+ inside voltage window B |
| dm_in_win_b | input | 1 | D- inside voltage window B |
| dp_pulled_up | input | 1 | D+ pulled to the supply |
| dm_pulled_up | input | 1 | D- pulled to the supply |
| batt_good | input | 1 | Battery-good status from the system |
| tick | input | 1 | Slow timebase pulse, one clock wide |
| chg_allow_pull | output | 1 | Drive the charge-permit line low (charging allowed) |
| chg_hi_current | output | 1 | High-current charging available |
| sw_open_pull | output | 1 | Drive the switch-status line low (switch closed) |
| data_sw_en | output | 1 | Close the data-path switch |

## Verification
A wrong state in the sequencer shows up as a wrong final status triple, or as a status change that appears before the timing chain has run. The sweep covers every comparator outcome and every window and pull-up pattern, each with both battery states. A timer that is too short or too long is caught by checks placed in the middle of detection and after the dead-battery window. A missed supply loss shows up as outputs that stay driven four clocks after the supply flag falls. A lost edge detector for the battery restart leaves the outputs released after the restart, where a result is expected.

// File: rtl/chg_pkg.sv
package chg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONTACT,
        ST_SETTLE,
        ST_PRIMARY,
        ST_SECONDARY,
        ST_WINDOW,
        ST_READY,
        ST_DEAD
    } det_state_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_HOST,
        SRC_CHG_HOST,
        SRC_DEDICATED,
        SRC_WIN_A,
        SRC_WIN_B,
        SRC_PULLUP,
        SRC_OPEN
    } src_kind_e;

    typedef struct packed {
        logic allow;
        logic hicur;
        logic close;
    } stat_s;

    localparam stat_s STAT_RELEASED = '{allow: 1'b0, hicur: 1'b0, close: 1'b0};

    function automatic stat_s status_for(src_kind_e kind, logic bat_ok);
        stat_s s;
        s = STAT_RELEASED;
        case (kind)
            SRC_HOST:      s = '{allow: 1'b1, hicur: 1'b0, close: bat_ok};
            SRC_CHG_HOST:  s = '{allow: 1'b1, hicur: 1'b1, close: bat_ok};
            SRC_DEDICATED,
            SRC_WIN_A,
            SRC_WIN_B:     s = '{allow: 1'b1, hicur: 1'b1, close: 1'b0};
            SRC_PULLUP,
            SRC_OPEN:      s = '{allow: 1'b1, hicur: 1'b0, close: 1'b0};
            default:       s = STAT_RELEASED;
        endcase
        return s;
    endfunction

    function automatic logic is_busy(det_state_e st);
        return (st == ST_CONTACT) || (st == ST_SETTLE) || (st == ST_PRIMARY) ||
               (st == ST_SECONDARY) || (st == ST_WINDOW);
    endfunction

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic stable_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= d_async[i];
                stable_q <= meta_q;
            end
        end
        assign q_sync[i] = stable_q;
    end
endmodule

// File: rtl/chg_tick_timer.sv
module chg_tick_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (step)  cnt_q <= cnt_q + 1'b1;
    end

    assign hit = step && (cnt_q == limit - 1'b1);

    // R12: the count never runs past the limit of the current phase
    p_count_in_range_r12: assert property (@(posedge clk) disable iff (rst)
        cnt_q < limit);
endmodule

// File: rtl/chg_window_classifier.sv
module chg_window_classifier
    import chg_pkg::*;
(
    input  logic [1:0] win_a,
    input  logic [1:0] win_b,
    input  logic [1:0] pulled_up,
    output src_kind_e  kind
);
    always_comb begin
        if (&win_a)          kind = SRC_WIN_A;
        else if (&win_b)     kind = SRC_WIN_B;
        else if (&pulled_up) kind = SRC_PULLUP;
        else                 kind = SRC_OPEN;
    end
endmodule

// File: rtl/chg_detect_fsm.sv
module chg_detect_fsm
    import chg_pkg::*;
#(
    parameter int CW        = 8,
    parameter int DCD_TICKS = 8,
    parameter int DEB_TICKS = 4,
    parameter int PRI_TICKS = 2,
    parameter int SEC_TICKS = 2,
    parameter int DBP_TICKS = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vbus,
    input  logic          contact,
    input  logic          prim,
    input  logic          sec,
    input  logic          bat,
    input  logic          tick,
    input  src_kind_e     win_kind,
    input  logic          hit,
    output logic [CW-1:0] limit,
    output logic          step,
    output logic          clr,
    output stat_s         stat
);
    localparam logic [CW-1:0] L_DCD = CW'(DCD_TICKS);
    localparam logic [CW-1:0] L_DEB = CW'(DEB_TICKS);
    localparam logic [CW-1:0] L_PRI = CW'(PRI_TICKS);
    localparam logic [CW-1:0] L_SEC = CW'(SEC_TICKS);
    localparam logic [CW-1:0] L_DBP = CW'(DBP_TICKS);
    localparam logic [CW-1:0] L_ONE = CW'(1);

    det_state_e st_q, st_d;
    src_kind_e  kind_q, kind_d;
    stat_s      stat_q, stat_d;
    logic       bat_q;
    logic       run;
    logic       bat_rise;
    logic       busy_now;

    assign bat_rise = bat && !bat_q;
    assign busy_now = is_busy(st_q);

    always_comb begin
        st_d   = st_q;
        kind_d = kind_q;
        limit  = L_ONE;
        run    = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (vbus) st_d = ST_CONTACT;
            end
            ST_CONTACT: begin
                run   = 1'b1;
                limit = L_DCD;
                if (contact)  st_d = ST_SETTLE;
                else if (hit) st_d = ST_WINDOW;
            end
            ST_SETTLE: begin
                run   = 1'b1;
                limit = L_DEB;
                if (hit) st_d = ST_PRIMARY;
            end
            ST_PRIMARY: begin
                run   = 1'b1;
                limit = L_PRI;
                if (hit) begin
                    if (prim) st_d = ST_SECONDARY;
                    else begin
                        kind_d = SRC_HOST;
                        st_d   = ST_READY;
                    end
                end
            end
            ST_SECONDARY: begin
                run   = 1'b1;
                limit = L_SEC;
                if (hit) begin
                    kind_d = sec ? SRC_DEDICATED : SRC_CHG_HOST;
                    st_d   = ST_READY;
                end
            end
            ST_WINDOW: begin
                kind_d = win_kind;
                st_d   = ST_READY;
            end
            ST_READY: begin
                run   = !bat;
                limit = L_DBP;
                if (hit) st_d = ST_DEAD;
            end
            ST_DEAD: begin
                if (bat_rise) st_d = ST_CONTACT;
            end
            default: st_d = ST_IDLE;
        endcase
        if (!vbus) begin
            st_d   = ST_IDLE;
            kind_d = SRC_NONE;
        end
    end

    assign step = tick && run;
    assign clr  = (st_d != st_q) || ((st_q == ST_READY) && bat);

    always_comb begin
        stat_d = stat_q;
        case (st_d)
            ST_IDLE,
            ST_DEAD:  stat_d = STAT_RELEASED;
            ST_READY: stat_d = status_for(kind_d, bat);
            default:  stat_d = stat_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            kind_q <= SRC_NONE;
            stat_q <= STAT_RELEASED;
            bat_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            kind_q <= kind_d;
            stat_q <= stat_d;
            bat_q  <= bat;
        end
    end

    assign stat = stat_q;

    // R1: supply loss forces the idle state on the next edge
    p_vbus_loss_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !vbus |=> (st_q == ST_IDLE));

    // R1: idle always presents released outputs
    p_idle_released_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> (stat_q == STAT_RELEASED));

    // R9: outputs frozen between two cycles of ongoing detection
    p_hold_busy_r9: assert property (@(posedge clk) disable iff (rst)
        busy_now |=> (!busy_now || $stable(stat_q)));

    // R5: a bad battery opens the switch by the next edge
    p_switch_needs_bat_r5: assert property (@(posedge clk) disable iff (rst)
        !bat |=> !stat_q.close);

    // R10: the expired state never grants charging
    p_dead_no_charge_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DEAD) |-> !stat_q.allow);
endmodule

// File: rtl/usb_chg_detect.sv
module usb_chg_detect
    import chg_pkg::*;
#(
    parameter int DCD_TICKS = 600,
    parameter int DEB_TICKS = 130,
    parameter int PRI_TICKS = 40,
    parameter int SEC_TICKS = 40,
    parameter int DBP_TICKS = 1920000
) (
    input  logic clk,
    input  logic rst,
    input  logic vbus_valid,
    input  logic dcd_contact,
    input  logic prim_is_charger,
    input  logic sec_is_dedicated,
    input  logic dp_in_win_a,
    input  logic dm_in_win_a,
    input  logic dp_in_win_b,
    input  logic dm_in_win_b,
    input  logic dp_pulled_up,
    input  logic dm_pulled_up,
    input  logic batt_good,
    input  logic tick,
    output logic chg_allow_pull,
    output logic chg_hi_current,
    output logic sw_open_pull,
    output logic data_sw_en
);
    localparam int M1    = (DCD_TICKS > DEB_TICKS) ? DCD_TICKS : DEB_TICKS;
    localparam int M2    = (PRI_TICKS > SEC_TICKS) ? PRI_TICKS : SEC_TICKS;
    localparam int M3    = (M1 > M2) ? M1 : M2;
    localparam int T_MAX = (M3 > DBP_TICKS) ? M3 : DBP_TICKS;
    localparam int CW    = $clog2(T_MAX + 1);
    localparam int NSYNC = 11;

    logic [NSYNC-1:0] raw_in, syn;
    logic             vbus_s, contact_s, prim_s, sec_s, bat_s;
    logic [1:0]       win_a_s, win_b_s, pu_s;
    src_kind_e        win_kind;
    logic [CW-1:0]    limit;
    logic             step, clr, hit;
    stat_s            stat;

    assign raw_in = {vbus_valid, dcd_contact, prim_is_charger, sec_is_dedicated,
                     dp_in_win_a, dm_in_win_a, dp_in_win_b, dm_in_win_b,
                     dp_pulled_up, dm_pulled_up, batt_good};

    chg_sync #(.WIDTH(NSYNC)) u_sync (
        .clk(clk), .rst(rst), .d_async(raw_in), .q_sync(syn)
    );

    assign {vbus_s, contact_s, prim_s, sec_s, win_a_s, win_b_s, pu_s, bat_s} = syn;

    chg_window_classifier u_win (
        .win_a(win_a_s), .win_b(win_b_s), .pulled_up(pu_s), .kind(win_kind)
    );

    chg_tick_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .clr(clr), .step(step), .limit(limit), .hit(hit)
    );

    chg_detect_fsm #(
        .CW(CW), .DCD_TICKS(DCD_TICKS), .DEB_TICKS(DEB_TICKS),
        .PRI_TICKS(PRI_TICKS), .SEC_TICKS(SEC_TICKS), .DBP_TICKS(DBP_TICKS)
    ) u_fsm (
        .clk(clk), .rst(rst), .vbus(vbus_s), .contact(contact_s),
        .prim(prim_s), .sec(sec_s), .bat(bat_s), .tick(tick),
        .win_kind(win_kind), .hit(hit), .limit(limit), .step(step),
        .clr(clr), .stat(stat)
    );

    assign chg_allow_pull = stat.allow;
    assign chg_hi_current = stat.hicur;
    assign sw_open_pull   = stat.close;
    assign data_sw_en     = stat.close;

    // R5 and R7: high current or a closed switch only ever come with a charge permit
    always_comb begin
        if (!rst) begin
            p_flags_need_allow_r5: assert ((!chg_hi_current && !data_sw_en) || chg_allow_pull);
        end
    end
endmodule

// File: tb/tb_usb_chg_detect.sv
module tb_usb_chg_detect;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vbus_valid = 0, dcd_contact = 0, prim_is_charger = 0, sec_is_dedicated = 0;
    logic dp_in_win_a = 0, dm_in_win_a = 0, dp_in_win_b = 0, dm_in_win_b = 0;
    logic dp_pulled_up = 0, dm_pulled_up = 0, batt_good = 0, tick = 1;
    logic chg_allow_pull, chg_hi_current, sw_open_pull, data_sw_en;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    usb_chg_detect #(
        .DCD_TICKS(8), .DEB_TICKS(4), .PRI_TICKS(2), .SEC_TICKS(2), .DBP_TICKS(40)
    ) dut (.*);

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] expv);
        logic [3:0] got;
        got = {chg_allow_pull, chg_hi_current, sw_open_pull, data_sw_en};
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s: got %b expected %b (allow,hicur,swlow,swen)", req, got, expv);
        end
    endtask

    task automatic set_lines(input logic [1:0] a, input logic [1:0] b, input logic [1:0] pu);
        {dp_in_win_a, dm_in_win_a} = a;
        {dp_in_win_b, dm_in_win_b} = b;
        {dp_pulled_up, dm_pulled_up} = pu;
    endtask

    task automatic run_case(input logic c, input logic p, input logic s,
                            input logic [1:0] a, input logic [1:0] b, input logic [1:0] pu,
                            input logic bat, input string req);
        logic det, close;
        if (c) begin
            det   = p;
            close = bat && !(p && s);
        end else begin
            det   = (&a) || (&b);
            close = 1'b0;
        end
        dcd_contact = c; prim_is_charger = p; sec_is_dedicated = s;
        set_lines(a, b, pu); batt_good = bat;
        cyc(4);
        vbus_valid = 1'b1;
        cyc(5);
        check("R9 hold during detection", 4'b0000);
        cyc(20);
        check(req, {1'b1, det, close, close});
        vbus_valid = 1'b0;
        cyc(4);
        check("R1 released after supply loss", 4'b0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(2);
        check("R1 reset state", 4'b0000);

        // contact path: every comparator outcome with both battery states
        for (int i = 0; i < 8; i++) begin
            logic p, s, bat;
            string req;
            {p, s, bat} = i[2:0];
            if (!p)      req = "R2/R5 host port";
            else if (!s) req = "R3/R5 charging host port";
            else         req = "R4/R5 dedicated charger";
            run_case(1'b1, p, s, 2'b00, 2'b00, 2'b00, bat, req);
        end

        // timeout path: all window and pull-up patterns, both battery states
        for (int i = 0; i < 128; i++) begin
            logic [1:0] a, b, pu;
            logic bat;
            {a, b, pu, bat} = i[6:0];
            run_case(1'b0, 1'b1, 1'b1, a, b, pu, bat,
                     ((&a) || (&b)) ? "R6 window match" : "R7 no window match");
        end

        // R8: slow insertion, contact only after timeout
        dcd_contact = 0; prim_is_charger = 1; sec_is_dedicated = 1;
        set_lines(2'b00, 2'b00, 2'b00); batt_good = 1;
        vbus_valid = 1;
        cyc(20);
        dcd_contact = 1;
        cyc(15);
        check("R8 late contact ignored", 4'b1000);
        vbus_valid = 0; dcd_contact = 0;
        cyc(4);

        // R10 and R11: dead battery expiry and restart
        dcd_contact = 1; prim_is_charger = 1; sec_is_dedicated = 0; batt_good = 0;
        vbus_valid = 1;
        cyc(25);
        check("R10 result before expiry", 4'b1100);
        cyc(20);
        batt_good = 1;
        cyc(4);
        check("R10 battery pulse, host switch closes", 4'b1111);
        batt_good = 0;
        cyc(30);
        check("R10 count restarted by pulse", 4'b1100);
        cyc(20);
        check("R10 expired releases outputs", 4'b0000);
        batt_good = 1;
        cyc(4);
        check("R11 outputs released during rerun", 4'b0000);
        cyc(20);
        check("R11 rerun result", 4'b1111);
        vbus_valid = 0;
        cyc(4);
        check("R1 supply loss from closed switch", 4'b0000);

        // R12: no tick, no progress
        tick = 0; dcd_contact = 1; prim_is_charger = 0; batt_good = 1;
        vbus_valid = 1;
        cyc(40);
        check("R12 stalled without tick", 4'b0000);
        tick = 1;
        cyc(25);
        check("R12 resumes with tick", 4'b1011);
        vbus_valid = 0;
        cyc(4);
        check("R1 final release", 4'b0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule